// File: doc/BRIEF.md
# Two-Stage DMA Channel Chaining Trigger

This block sits next to a multi-channel DMA engine and lets one channel's completion start another channel without software. It holds two independent chaining groups. Each group names a source channel, a destination channel, which kinds of source completion count as a trigger, an interrupt enable field and a group enable. When an enabled group sees a selected completion event on its source channel, the block emits a one-clock start pulse on the destination channel's start line.

Software programs the groups through a small register port with a per-bit write mask, so the source-side fields and the destination-side fields of a group can be updated by separate agents without a read-modify-write race. Each firing also sets a sticky per-group status bit, cleared by writing 1. When the group's interrupt field allows it, that bit drives a chained-interrupt output.

Top module: `dma_chain_trigger`

## Requirements
- R1: After reset, both group registers and the status register read 0, and no start pulse or interrupt is active.
- R2: Group 0 is at offset 0x28 and group 1 at 0x2c. In each group register, bits 5:0 hold the one-based source id, bits 13:8 hold the one-based destination id, bits 19:16 are trigger selects, bits 23:20 are the interrupt field and bit 24 is the enable. All other bits read 0. The status register is at offset 0x30, with bit g holding group g's status. Any other offset reads 0.
- R3: A write updates only the bits set in `reg_wmask`, so new = (old & ~mask) | (wdata & mask). A source-side write leaves the destination id unchanged, and the reverse also holds.
- R4: The trigger selects map as follows: bit 16 is fragment done, bit 17 is block done, bit 18 is transfer done and bit 19 is list done. An event of a kind that is not selected does not fire the group.
- R5: When a group fires on a sampled event, the destination channel (id minus 1) gets a start pulse in the next cycle. Each event cycle gives exactly one pulse cycle.
- R6: If several trigger bits are set, any selected event fires the group. If none is set, the group never fires.
- R7: A group with bit 24 clear never fires.
- R8: A group whose source or destination id is 0 or greater than NUM_CH never fires. Id NUM_CH is valid.
- R9: The two groups fire independently in the same cycle. When both target the same destination, that destination sees a single pulse.
- R10: Each firing sets the group's sticky status bit. Writing 1 to the bit (with its mask bit set) clears it. A firing in the same cycle as a clear leaves the bit set.
- R11: `chain_irq[g]` is high while status bit g is set and group g's interrupt field is nonzero.
- R12: Events on any channel other than the group's source channel do not fire the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write enable |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frag_done | input | NUM_CH | Fragment-complete event, one bit per channel |
| blk_done | input | NUM_CH | Block-complete event, one bit per channel |
| xfer_done | input | NUM_CH | Transfer-complete event, one bit per channel |
| list_done | input | NUM_CH | Linked-list-complete event, one bit per channel |
| dst_start | output | NUM_CH | Start pulse, one bit per channel |
| chain_stat | output | 2 | Sticky per-group fire status |
| chain_irq | output | 2 | Per-group chained interrupt |

## Verification
The bench builds the block with NUM_CH=6. With this value, a 6-bit id field can be programmed past the channel count: ids 7 through 63 must be ignored, while id 6 is the last valid channel. The random phase draws ids from 0 to 7, so zero, boundary and out-of-range ids occur often. It also mixes full, source-only and destination-only masked writes with sparse events on all four completion kinds.

// File: rtl/dma_chain_trigger.sv
module dma_chain_trigger #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] GRP0_ADDR = 'h28,
  parameter logic [ADDR_W-1:0] GRP1_ADDR = 'h2c,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_wmask,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] frag_done,
  input  logic [NUM_CH-1:0] blk_done,
  input  logic [NUM_CH-1:0] xfer_done,
  input  logic [NUM_CH-1:0] list_done,
  output logic [NUM_CH-1:0] dst_start,
  output logic [1:0]        chain_stat,
  output logic [1:0]        chain_irq
);
  localparam int NGRP = 2;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [31:0] CFG_USED = 32'h01FF_3F3F;

  logic [31:0]       cfg [NGRP];
  logic [NGRP-1:0]   stat, fire, grp_sel, clr;
  logic [NUM_CH-1:0] hit [NGRP];
  logic [NUM_CH-1:0] start_q;

  for (genvar g = 0; g < NGRP; g++) begin : grp
    localparam logic [ADDR_W-1:0] GA = (g == 0) ? GRP0_ADDR : GRP1_ADDR;
    logic [5:0]      sid, did, sm1, dm1;
    logic            sv, dv;
    logic [3:0]      ev;
    logic [CH_W-1:0] sidx, didx;

    assign sid  = cfg[g][5:0];
    assign did  = cfg[g][13:8];
    assign sm1  = sid - 6'd1;
    assign dm1  = did - 6'd1;
    assign sidx = sm1[CH_W-1:0];
    assign didx = dm1[CH_W-1:0];
    assign sv   = (sid != 6'd0) && (int'(sid) <= NUM_CH);
    assign dv   = (did != 6'd0) && (int'(did) <= NUM_CH);

    always_comb begin
      ev = '0;
      if (sv) ev = {list_done[sidx], xfer_done[sidx], blk_done[sidx], frag_done[sidx]};
    end

    assign fire[g]      = cfg[g][24] & sv & dv & (|(cfg[g][19:16] & ev));
    assign hit[g]       = fire[g] ? (NUM_CH'(1) << didx) : '0;
    assign grp_sel[g]   = reg_wr && (reg_addr == GA);
    assign clr[g]       = reg_wr && (reg_addr == STAT_ADDR) && reg_wmask[g] && reg_wdata[g];
    assign chain_irq[g] = stat[g] & (|cfg[g][23:20]);

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_sel[g] |=> $stable(cfg[g]));
    assert_stat_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stat[g] && !clr[g] |=> stat[g]);
    assert_stat_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire[g] |=> stat[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NGRP; i++) cfg[i] <= '0;
      stat    <= '0;
      start_q <= '0;
    end else begin
      for (int i = 0; i < NGRP; i++)
        if (grp_sel[i]) cfg[i] <= ((cfg[i] & ~reg_wmask) | (reg_wdata & reg_wmask)) & CFG_USED;
      stat    <= fire | (stat & ~clr);
      start_q <= hit[0] | hit[1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == GRP0_ADDR)      reg_rdata = cfg[0];
    else if (reg_addr == GRP1_ADDR) reg_rdata = cfg[1];
    else if (reg_addr == STAT_ADDR) reg_rdata = {30'd0, stat};
  end

  assign dst_start  = start_q;
  assign chain_stat = stat;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (cfg[0] == '0 && cfg[1] == '0 && stat == '0 && dst_start == '0));
  assert_start_needs_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dst_start) |-> $past(|(frag_done | blk_done | xfer_done | list_done)));
  assert_start_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|dst_start) |-> $past(cfg[0][24] || cfg[1][24]));
endmodule

// File: tb/sim_dma_chain_trigger.sv
module sim_dma_chain_trigger;
  localparam int NCH = 6;
  localparam logic [7:0] G0 = 8'h28, G1 = 8'h2c, ST = 8'h30;
  localparam logic [31:0] USED = 32'h01FF_3F3F;
  localparam logic [31:0] SRC_SIDE = 32'h01FF_003F;
  localparam logic [31:0] DST_SIDE = 32'h0100_3F00;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_wmask = '0, reg_rdata;
  logic [NCH-1:0] frag_done = '0, blk_done = '0, xfer_done = '0, list_done = '0, dst_start;
  logic [1:0] chain_stat, chain_irq;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] mcfg [2];
  logic [1:0] mstat;

  dma_chain_trigger #(.NUM_CH(NCH), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .frag_done(frag_done), .blk_done(blk_done), .xfer_done(xfer_done),
    .list_done(list_done), .dst_start(dst_start), .chain_stat(chain_stat),
    .chain_irq(chain_irq));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int s, int d, logic [3:0] t, logic [3:0] im, logic en);
    return {7'd0, en, im, t, 2'd0, 6'(d), 2'd0, 6'(s)};
  endfunction

  function automatic logic mfire(logic [31:0] c, logic [NCH-1:0] f, logic [NCH-1:0] b,
                                 logic [NCH-1:0] x, logic [NCH-1:0] l);
    int s = int'(c[5:0]);
    int d = int'(c[13:8]);
    if (!c[24] || s == 0 || s > NCH || d == 0 || d > NCH) return 1'b0;
    return (c[16] & f[s-1]) | (c[17] & b[s-1]) | (c[18] & x[s-1]) | (c[19] & l[s-1]);
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [31:0] m);
    @(negedge clk);
    frag_done = '0; blk_done = '0; xfer_done = '0; list_done = '0;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == G0) mcfg[0] = ((mcfg[0] & ~m) | (d & m)) & USED;
    if (a == G1) mcfg[1] = ((mcfg[1] & ~m) | (d & m)) & USED;
    if (a == ST) mstat = mstat & ~(d[1:0] & m[1:0]);
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic step(string tag, logic [NCH-1:0] f, logic [NCH-1:0] b,
                      logic [NCH-1:0] x, logic [NCH-1:0] l, logic [1:0] clr);
    logic [1:0] fr;
    logic [NCH-1:0] es;
    @(negedge clk);
    frag_done = f; blk_done = b; xfer_done = x; list_done = l;
    reg_wr = (clr != 2'b00); reg_addr = ST; reg_wdata = {30'd0, clr}; reg_wmask = {30'd0, clr};
    es = '0;
    for (int g = 0; g < 2; g++) begin
      fr[g] = mfire(mcfg[g], f, b, x, l);
      if (fr[g]) es[int'(mcfg[g][13:8]) - 1] = 1'b1;
    end
    @(posedge clk); #1;
    reg_wr = 1'b0;
    mstat = fr | (mstat & ~clr);
    chk({tag, " start"}, 32'(dst_start), 32'(es));
    chk({tag, " stat"}, 32'(chain_stat), 32'(mstat));
    chk({tag, " irq"}, 32'(chain_irq), 32'(mstat & {|mcfg[1][23:20], |mcfg[0][23:20]}));
  endtask

  initial begin
    logic [31:0] junk;
    junk = $urandom(32'd20240607);
    mcfg[0] = '0; mcfg[1] = '0; mstat = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1 start at reset", 32'(dst_start), 32'd0);
    @(negedge clk) rst_n = 1'b1;

    rd("R1 grp0", G0, 32'd0);
    rd("R1 grp1", G1, 32'd0);
    rd("R1 stat", ST, 32'd0);
    chk("R1 irq", 32'(chain_irq), 32'd0);

    wr(G0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd("R2 used bits", G0, 32'h01FF_3F3F);
    rd("R2 other offset", 8'h34, 32'd0);
    wr(G0, 32'd0, 32'hFFFF_FFFF);

    wr(G0, mk(2, 0, 4'b0001, 4'd0, 1'b1), SRC_SIDE);
    wr(G0, mk(0, 4, 4'b0000, 4'd0, 1'b1), DST_SIDE);
    rd("R3 merged sides", G0, mk(2, 4, 4'b0001, 4'd0, 1'b1));
    wr(G0, mk(5, 0, 4'b0001, 4'd0, 1'b1), SRC_SIDE);
    rd("R3 dst kept", G0, mk(5, 4, 4'b0001, 4'd0, 1'b1));
    wr(G0, mk(2, 0, 4'b0001, 4'd0, 1'b1), SRC_SIDE);

    step("R5 frag fires", 6'b000010, 0, 0, 0, 2'b00);
    step("R5 one wide", 0, 0, 0, 0, 2'b00);
    step("R4 blk not selected", 0, 6'b000010, 0, 0, 2'b00);
    for (int k = 0; k < 4; k++) begin
      wr(G0, mk(2, 4, 4'(1 << k), 4'd0, 1'b1), 32'hFFFF_FFFF);
      step("R4 frag kind", 6'b000010, 0, 0, 0, 2'b00);
      step("R4 blk kind", 0, 6'b000010, 0, 0, 2'b00);
      step("R4 xfer kind", 0, 0, 6'b000010, 0, 2'b00);
      step("R4 list kind", 0, 0, 0, 6'b000010, 2'b00);
    end
    wr(G0, mk(2, 4, 4'b0000, 4'd0, 1'b1), 32'hFFFF_FFFF);
    step("R6 no select", 6'h3F, 6'h3F, 6'h3F, 6'h3F, 2'b00);
    wr(G0, mk(2, 4, 4'b1111, 4'd0, 1'b1), 32'hFFFF_FFFF);
    step("R6 any select", 0, 0, 6'b000010, 0, 2'b00);
    step("R12 other channel", 6'b111101, 6'b111101, 6'b111101, 6'b111101, 2'b00);
    wr(G0, mk(2, 4, 4'b1111, 4'd0, 1'b0), 32'hFFFF_FFFF);
    step("R7 disabled", 6'h3F, 6'h3F, 6'h3F, 6'h3F, 2'b00);
    wr(G0, mk(0, 4, 4'b1111, 4'd0, 1'b1), 32'hFFFF_FFFF);
    step("R8 src id zero", 6'h3F, 6'h3F, 6'h3F, 6'h3F, 2'b00);
    wr(G0, mk(2, 7, 4'b1111, 4'd0, 1'b1), 32'hFFFF_FFFF);
    step("R8 dst id over", 6'h3F, 0, 0, 0, 2'b00);
    wr(G0, mk(6, 6, 4'b1111, 4'd0, 1'b1), 32'hFFFF_FFFF);
    step("R8 id boundary", 6'b100000, 0, 0, 0, 2'b00);

    wr(G0, mk(1, 3, 4'b0001, 4'b0001, 1'b1), 32'hFFFF_FFFF);
    wr(G1, mk(2, 3, 4'b1000, 4'b0000, 1'b1), 32'hFFFF_FFFF);
    step("R9 shared dst", 6'b000001, 0, 0, 6'b000010, 2'b00);
    wr(G1, mk(2, 5, 4'b1000, 4'b0000, 1'b1), 32'hFFFF_FFFF);
    step("R9 both groups", 6'b000001, 0, 0, 6'b000010, 2'b00);
    step("R11 irq follows mask", 0, 0, 0, 0, 2'b00);
    step("R10 w1c", 0, 0, 0, 0, 2'b01);
    rd("R10 stat after clear", ST, 32'(mstat));
    step("R10 set wins", 0, 0, 0, 6'b000010, 2'b10);
    wr(ST, 32'h3, 32'h0);
    rd("R10 masked clear ignored", ST, 32'(mstat));

    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 5);
      if (op == 0) begin
        logic [31:0] m;
        int sel;
        sel = int'($urandom % 3);
        m = (sel == 0) ? 32'hFFFF_FFFF : (sel == 1) ? SRC_SIDE : DST_SIDE;
        wr(($urandom % 2) ? G1 : G0,
           mk(int'($urandom % 8), int'($urandom % 8), 4'($urandom), 4'($urandom), ($urandom % 4) != 0), m);
      end else if (op == 1) begin
        int a;
        a = int'($urandom % 3);
        if (a == 0) rd("R2 rand grp0", G0, mcfg[0]);
        else if (a == 1) rd("R2 rand grp1", G1, mcfg[1]);
        else rd("R10 rand stat", ST, 32'(mstat));
      end else begin
        step("R9 rand step", 6'($urandom & $urandom), 6'($urandom & $urandom),
             6'($urandom & $urandom), 6'($urandom & $urandom),
             (($urandom % 4) == 0) ? 2'($urandom) : 2'b00);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule